// File: doc/BRIEF.md
# Real-Time Clock Alarm Match and Shared Wave/Interrupt Pin

This block sits next to the timekeeping counters of a real-time clock. It compares the current minutes, hours and day or date with a set of three alarm registers. Once per minute, at the moment the seconds counter wraps to 00, it decides whether the alarm condition holds and, if so, sets a sticky alarm flag. A mask bit in bit 7 of each alarm register takes that field out of the comparison, and this is how the alarm rate is selected. Bit 6 of the day/date alarm register chooses between a weekday comparison and a calendar-date comparison.

The same logic drives one open-drain output pin. With interrupt mode selected, the pin is pulled low while any alarm flag is set together with its enable. With interrupt mode cleared, the pin carries a square wave that is divided down from the 32.768 kHz oscillator. A two-bit rate selector picks 1 Hz, 4.096 kHz, 8.192 kHz or the oscillator itself. The oscillator level arrives already synchronised to the system clock. The divider depth is a parameter, so a shortened configuration can exercise the slowest tap in a short run.

Top module: `rtc_alarm_out`

## Requirements
- R1: During reset and on the first cycle after it, the alarm flag `a2Flag` reads 0 and `pinLowEn` reads 0 (pin released).
- R2: At a `minuteTick` pulse the flag is set when every field passes. A field passes when its mask bit is 1 or its value compares equal. The mask bits are bit 7 of `almMinReg`, `almHourReg` and `almDayReg`. With all three masks at 1, every tick sets the flag.
- R3: With the masks (day, hour, minute) = (1,1,0), a tick sets the flag only when `curMin` equals `almMinReg[6:0]` as a BCD value.
- R4: With the masks (1,0,0), minutes and hours must both match. Each hour register is first reduced to a 0–23 value. Bit 6 = 1 means 12-hour form, with bit 5 as PM, bit 4 as tens and bits 3:0 as ones; 12 AM counts as 0 and 12 PM as 12. Bit 6 = 0 means 24-hour form, with bits 5:4 as tens. So 7 PM in 12-hour form matches 19 in 24-hour form.
- R5: With all masks at 0, bit 6 of `almDayReg` selects the third field. At 0 the field is `curDate` against `almDayReg[5:0]`. At 1 it is `curDay` against `almDayReg[3:0]`. The field that is not selected has no effect.
- R6: Without a `minuteTick` pulse the flag is never set, whatever the time and alarm values.
- R7: Once set, the flag stays set until a cycle with `a2FlagClr` high. When a clear and a setting tick fall in the same cycle, the flag stays set.
- R8: With `intcn` = 1, `pinLowEn` equals (`a2Flag` and `a2Ie`) or (`a1Flag` and `a1Ie`), one clock after those inputs.
- R9: With `intcn` = 0, the pin carries a 50 % square wave (`pinLowEn` = 0 is the high phase). `rsSel` = 2'b10 gives a period of 4 oscillator periods. 2'b01 gives 8. 2'b00 gives 2^`DIV_BITS` (32768 by default, i.e. 1 Hz).
- R10: With `intcn` = 0 and `rsSel` = 2'b11, the pin follows the oscillator level, with the same period and duty as `oscIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscIn | input | 1 | 32.768 kHz oscillator level, synchronised to clk |
| minuteTick | input | 1 | One-cycle pulse when seconds wrap to 00 |
| curMin | input | 7 | Current minutes, BCD |
| curHour | input | 7 | Current hours, register form (bit 6 = 12-hour mode) |
| curDay | input | 3 | Current weekday 1–7 |
| curDate | input | 6 | Current date, BCD |
| almMinReg | input | 8 | Alarm minutes; bit 7 is the mask |
| almHourReg | input | 8 | Alarm hours; bit 7 is the mask |
| almDayReg | input | 8 | Alarm day/date; bit 7 is the mask, bit 6 selects day |
| rsSel | input | 2 | Square-wave rate select |
| intcn | input | 1 | 1: pin is interrupt, 0: pin is square wave |
| a2Ie | input | 1 | Alarm flag interrupt enable |
| a1Ie | input | 1 | Enable for the other alarm's flag |
| a1Flag | input | 1 | Other alarm's flag |
| a2FlagClr | input | 1 | Clears the alarm flag |
| a2Flag | output | 1 | Sticky alarm flag |
| pinLowEn | output | 1 | 1 pulls the open-drain pin low |

## Verification
The hardest case to reach from the ports is a mismatch that only the hour conversion can produce. That happens when a 12-hour alarm value and a 24-hour current value name the same hour in different encodings, or name neighbouring hours. The stimulus sweeps all eight mask codes, both day/date selections and every combination of matching and non-matching fields. For the hour field it alternates between 7 PM against 19 and midnight written as 12 AM against 00. The field left out of the day/date comparison is always driven to the opposite outcome, so a leak from it would show up in the flag. The slowest divider tap is reached by shrinking the divider depth.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic divStep;   // oscillator rising edge
    logic oscLvl;    // registered oscillator level
    logic evalAlarm; // seconds wrapped to 00
  } strobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic minEq;
    logic hrEq;
    logic dayEq;
    logic dateEq;
  } match_t;

  typedef enum logic [1:0] {
    WAVE_SLOW  = 2'b00,
    WAVE_DIV8  = 2'b01,
    WAVE_DIV4  = 2'b10,
    WAVE_OSC   = 2'b11
  } wave_e;

  // reduce an hour register to 0..23
  function automatic logic [4:0] hourTo24(input logic [6:0] r);
    logic [4:0] ones;
    logic [4:0] h;
    ones = {1'b0, r[3:0]};
    if (r[6]) begin
      h = (r[4] ? 5'd10 : 5'd0) + ones;
      if (h == 5'd12) h = r[5] ? 5'd12 : 5'd0;
      else if (r[5]) h = h + 5'd12;
    end else begin
      h = (r[5] ? 5'd20 : (r[4] ? 5'd10 : 5'd0)) + ones;
    end
    return h;
  endfunction

endpackage

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic [6:0] curMin,
  input  logic [6:0] curHour,
  input  logic [2:0] curDay,
  input  logic [5:0] curDate,
  input  logic [7:0] almMinReg,
  input  logic [7:0] almHourReg,
  input  logic [7:0] almDayReg,
  input  logic [1:0] rsSel,
  output match_t     match,
  output logic       waveOut
);

  localparam int SLOW_TAP = DIV_BITS - 1;

  logic [DIV_BITS-1:0] divCnt;
  logic [3:0]          taps;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (strb.divStep) divCnt <= divCnt + 1'b1;
  end

  // tap vector indexed by rate code
  assign taps[WAVE_SLOW] = divCnt[SLOW_TAP];
  assign taps[WAVE_DIV8] = divCnt[2];
  assign taps[WAVE_DIV4] = divCnt[1];
  assign taps[WAVE_OSC]  = strb.oscLvl;

  generate
    if (DIV_BITS < 3) begin : g_bad
      initial $error("DIV_BITS must be at least 3");
    end
  endgenerate

  assign waveOut = taps[rsSel];

  logic [4:0] curH24;
  logic [4:0] almH24;
  assign curH24 = hourTo24(curHour);
  assign almH24 = hourTo24(almHourReg[6:0]);

  always_comb begin
    match.minEq  = (curMin == almMinReg[6:0]);
    match.hrEq   = (curH24 == almH24);
    match.dayEq  = ({1'b0, curDay} == almDayReg[3:0]);
    match.dateEq = (curDate == almDayReg[5:0]);
  end

endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    oscIn,
  input  logic    minuteTick,
  input  logic    maskMin,
  input  logic    maskHour,
  input  logic    maskDay,
  input  logic    useDay,
  input  match_t  match,
  input  logic    waveOut,
  input  logic    intcn,
  input  logic    a2Ie,
  input  logic    a1Ie,
  input  logic    a1Flag,
  input  logic    a2FlagClr,
  output strobe_t strb,
  output logic    a2Flag,
  output logic    pinLowEn
);

  logic oscPrev;
  logic fieldHit;
  logic irqReq;

  always_ff @(posedge clk) begin
    if (!rstN) oscPrev <= 1'b0;
    else       oscPrev <= oscIn;
  end

  always_comb begin
    strb.divStep   = oscIn & ~oscPrev;
    strb.oscLvl    = oscPrev;
    strb.evalAlarm = minuteTick;
  end

  assign fieldHit = (maskMin  | match.minEq) &
                    (maskHour | match.hrEq)  &
                    (maskDay  | (useDay ? match.dayEq : match.dateEq));

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) a2Flag <= 1'b0;
    else if (strb.evalAlarm && fieldHit) a2Flag <= 1'b1;
    else if (a2FlagClr) a2Flag <= 1'b0;
  end

  assign irqReq = (a2Flag & a2Ie) | (a1Flag & a1Ie);

  always_ff @(posedge clk) begin
    if (!rstN) pinLowEn <= 1'b0;
    else       pinLowEn <= intcn ? irqReq : ~waveOut;
  end

endmodule

// File: rtl/rtc_alarm_out.sv
module rtc_alarm_out
  import rtc_alarm_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscIn,
  input  logic       minuteTick,
  input  logic [6:0] curMin,
  input  logic [6:0] curHour,
  input  logic [2:0] curDay,
  input  logic [5:0] curDate,
  input  logic [7:0] almMinReg,
  input  logic [7:0] almHourReg,
  input  logic [7:0] almDayReg,
  input  logic [1:0] rsSel,
  input  logic       intcn,
  input  logic       a2Ie,
  input  logic       a1Ie,
  input  logic       a1Flag,
  input  logic       a2FlagClr,
  output logic       a2Flag,
  output logic       pinLowEn
);

  strobe_t strb;
  match_t  match;
  logic    waveOut;

  rtc_alarm_dp #(.DIV_BITS(DIV_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .curMin(curMin), .curHour(curHour), .curDay(curDay), .curDate(curDate),
    .almMinReg(almMinReg), .almHourReg(almHourReg), .almDayReg(almDayReg),
    .rsSel(rsSel), .match(match), .waveOut(waveOut)
  );

  rtc_alarm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .minuteTick(minuteTick),
    .maskMin(almMinReg[7]), .maskHour(almHourReg[7]), .maskDay(almDayReg[7]),
    .useDay(almDayReg[6]), .match(match), .waveOut(waveOut),
    .intcn(intcn), .a2Ie(a2Ie), .a1Ie(a1Ie), .a1Flag(a1Flag),
    .a2FlagClr(a2FlagClr), .strb(strb), .a2Flag(a2Flag), .pinLowEn(pinLowEn)
  );

endmodule

// File: rtl/rtc_alarm_out_chk.sv
module rtc_alarm_out_chk (
  input logic       clk,
  input logic       rstN,
  input logic       oscIn,
  input logic       minuteTick,
  input logic [6:0] curMin,
  input logic [6:0] curHour,
  input logic [2:0] curDay,
  input logic [5:0] curDate,
  input logic [7:0] almMinReg,
  input logic [7:0] almHourReg,
  input logic [7:0] almDayReg,
  input logic [1:0] rsSel,
  input logic       intcn,
  input logic       a2Ie,
  input logic       a1Ie,
  input logic       a1Flag,
  input logic       a2FlagClr,
  input logic       a2Flag,
  input logic       pinLowEn
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!a2Flag && !pinLowEn));

  // R2
  all_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (minuteTick && almMinReg[7] && almHourReg[7] && almDayReg[7]) |=> a2Flag);

  // R6
  no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!a2Flag && !minuteTick) |=> !a2Flag);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (a2Flag && !a2FlagClr) |=> a2Flag);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (a2FlagClr && !minuteTick) |=> !a2Flag);

  // R8
  int_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    intcn |=> (pinLowEn == $past((a2Flag && a2Ie) || (a1Flag && a1Ie))));

endmodule

bind rtc_alarm_out rtc_alarm_out_chk u_chk (.*);

// File: tb/rtc_alarm_out_tb.sv
`timescale 1ns/1ps
module rtc_alarm_out_tb;

  localparam int DIV_BITS = 6;
  localparam int OSC_HALF = 2; // clk cycles per oscillator half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscIn = 1'b0;
  logic minuteTick = 1'b0;
  logic [6:0] curMin = '0;
  logic [6:0] curHour = '0;
  logic [2:0] curDay = '0;
  logic [5:0] curDate = '0;
  logic [7:0] almMinReg = '0;
  logic [7:0] almHourReg = '0;
  logic [7:0] almDayReg = '0;
  logic [1:0] rsSel = '0;
  logic intcn = 1'b1;
  logic a2Ie = 1'b0;
  logic a1Ie = 1'b0;
  logic a1Flag = 1'b0;
  logic a2FlagClr = 1'b0;
  logic a2Flag;
  logic pinLowEn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_out #(.DIV_BITS(DIV_BITS)) u_dut (.*);

  initial begin
    forever begin
      repeat (OSC_HALF) @(negedge clk);
      oscIn = ~oscIn;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFlag();
    a2FlagClr = 1'b1;
    cyc(1);
    a2FlagClr = 1'b0;
  endtask

  task automatic tick();
    minuteTick = 1'b1;
    cyc(1);
    minuteTick = 1'b0;
  endtask

  // wave high = pin released; measure one high phase and the whole period
  task automatic measure(output int hi, output int per);
    int lo;
    hi = 0; lo = 0;
    while (pinLowEn == 1'b0) cyc(1);
    while (pinLowEn == 1'b1) cyc(1);
    while (pinLowEn == 1'b0) begin hi++; cyc(1); end
    while (pinLowEn == 1'b1) begin lo++; cyc(1); end
    per = hi + lo;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, per, expPer;
    cyc(3);
    // R1 reset state
    chk("R1 flag in reset", a2Flag, 0);
    chk("R1 pin in reset", pinLowEn, 0);
    rstN = 1'b1;
    cyc(1);
    chk("R1 flag after reset", a2Flag, 0);
    chk("R1 pin after reset", pinLowEn, 0);

    // sweep masks, day/date select and per-field equality (R2..R6)
    for (int mk = 0; mk < 8; mk++) begin
      for (int dd = 0; dd < 2; dd++) begin
        for (int eq = 0; eq < 8; eq++) begin
          int exp;
          string req;
          logic hm, hh, hd;
          hm = eq[0]; hh = eq[1]; hd = eq[2];
          almMinReg = {mk[0], 7'h37};
          curMin = hm ? 7'h37 : 7'h38;
          if (((mk + eq) % 2) == 0) begin
            almHourReg = {mk[1], 7'h67};          // 7 PM, 12-hour form
            curHour = hh ? 7'h19 : 7'h18;         // 24-hour form
          end else begin
            almHourReg = {mk[1], 7'h00};          // 00, 24-hour form
            curHour = hh ? 7'h52 : 7'h41;         // 12 AM / 1 AM, 12-hour form
          end
          if (dd == 0) begin
            almDayReg = {mk[2], 1'b0, 6'h25};
            curDate = hd ? 6'h25 : 6'h26;
            curDay = hd ? 3'd4 : 3'd5;            // unselected field opposite
          end else begin
            almDayReg = {mk[2], 1'b1, 6'h03};
            curDay = hd ? 3'd3 : 3'd4;
            curDate = hd ? 6'h13 : 6'h03;         // unselected field opposite
          end
          clearFlag();
          cyc(1);
          chk("R6 no tick no flag", a2Flag, 0);
          tick();
          exp = ((mk[0] | hm) & (mk[1] | hh) & (mk[2] | hd)) ? 1 : 0;
          case (mk)
            7: req = "R2 all masked";
            6: req = "R3 minute match";
            4: req = "R4 hour and minute";
            0: req = "R5 day or date";
            default: req = "R2 per-field mask";
          endcase
          chk(req, a2Flag, exp);
        end
      end
    end

    // R7 sticky flag and priority
    almMinReg = 8'h80; almHourReg = 8'h80; almDayReg = 8'h80;
    clearFlag();
    tick();
    cyc(5);
    chk("R7 flag held", a2Flag, 1);
    a2FlagClr = 1'b1; minuteTick = 1'b1;
    cyc(1);
    a2FlagClr = 1'b0; minuteTick = 1'b0;
    chk("R7 set beats clear", a2Flag, 1);
    clearFlag();
    chk("R7 clear", a2Flag, 0);

    // R8 interrupt mode
    intcn = 1'b1; a2Ie = 1'b1;
    cyc(2);
    chk("R8 idle pin", pinLowEn, 0);
    tick();
    cyc(1);
    chk("R8 alarm drives pin", pinLowEn, 1);
    a2Ie = 1'b0;
    cyc(2);
    chk("R8 disabled releases", pinLowEn, 0);
    a1Flag = 1'b1; a1Ie = 1'b1;
    cyc(2);
    chk("R8 other alarm", pinLowEn, 1);
    a1Ie = 1'b0;
    cyc(2);
    chk("R8 other disabled", pinLowEn, 0);
    a1Flag = 1'b0; a2Ie = 1'b1;
    clearFlag();
    cyc(1);
    chk("R8 cleared releases", pinLowEn, 0);

    // R9 / R10 square wave rates
    intcn = 1'b0;
    for (int rs = 0; rs < 4; rs++) begin
      rsSel = rs[1:0];
      cyc(4);
      measure(hi, per);
      case (rs)
        0: expPer = 2 * OSC_HALF * (1 << DIV_BITS);
        1: expPer = 2 * OSC_HALF * 8;
        2: expPer = 2 * OSC_HALF * 4;
        default: expPer = 2 * OSC_HALF;
      endcase
      if (rs == 3) begin
        chk("R10 osc period", per, expPer);
        chk("R10 osc high", hi, expPer / 2);
      end else begin
        chk("R9 wave period", per, expPer);
        chk("R9 wave high", hi, expPer / 2);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule